// File: doc/BRIEF.md
# Receiver Reset and CDR-Mode Sequencer

This block drives the reset and clock-data-recovery (CDR) control lines of one serial transceiver receiver. It brings the receive path up after the transmit PLL locks and takes it down and back up when the link is lost. In manual CDR mode it first holds the CDR on the reference clock for a set dwell. It then switches the CDR to track the incoming data, and after a second dwell it releases the receiver digital reset. In automatic CDR mode the CDR picks its own mode. The sequencer only watches the frequency-lock status and keeps the digital reset applied until that status has been steady for a set number of cycles.

PLL lock, CDR frequency lock and signal detect arrive from other clock domains, so each passes through a synchroniser of `SYNC_STAGES` flops before the state machine sees it. The error flag comes from user logic in the same clock domain and is used as it arrives. User logic raises this flag on phase-compensation FIFO overflow or underflow, or on corrupted data. Every dwell is a parameter counted in clock cycles. All four outputs are taken straight from flops.

Top module: `rxrst_seq`

## Requirements
- R1: Manual mode (`cdr_auto_i`=0). The synchronised PLL lock moves the block from its wait state into the reference dwell. Counted from the edge where `pll_lock_i` is first seen high, `lock_ref_o` stays high for `SYNC_STAGES`+1+`REF_DWELL_CYC` cycles. In the same cycle that `lock_ref_o` falls, `lock_data_o` rises. The two outputs are never high together.
- R2: Manual mode. `rx_dig_rst_o` is released exactly `DATA_DWELL_CYC` cycles after `lock_data_o` rises. While it is released, `lock_data_o` is high and `lock_ref_o` is low.
- R3: When `pll_lock_i` falls, the outputs show the following `SYNC_STAGES`+1 cycles later: `rx_dig_rst_o`=1, `link_up_o`=0, `lock_ref_o`=1, `lock_data_o`=0. When PLL lock returns, the whole sequence restarts.
- R4: Automatic mode (`cdr_auto_i`=1, sampled when PLL lock is first seen). After PLL lock, `lock_ref_o` and `lock_data_o` are both 0. `rx_dig_rst_o` is released `SYNC_STAGES`+`FREQ_STABLE_CYC` cycles after `freq_lock_i` rises and stays high.
- R5: Automatic mode, link up. A fall of `freq_lock_i` asserts `rx_dig_rst_o` and clears `link_up_o` `SYNC_STAGES`+1 cycles later. Any low cycle of the synchronised frequency lock restarts the stability count.
- R6: A cycle with `rx_err_i`=1 while the link is up, and with no PLL or link loss, gives `rx_dig_rst_o`=1 and `link_up_o`=0 for exactly 2 cycles. The link then comes back up. The lock outputs do not change.
- R7: Manual mode. A fall of `sig_det_i` during the dwells or while the link is up gives `lock_ref_o`=1, `lock_data_o`=0 and `rx_dig_rst_o`=1 `SYNC_STAGES`+1 cycles later. When signal detect returns, the reference dwell restarts.
- R8: While `rst_n` is low: `lock_ref_o`=1, `lock_data_o`=0, `rx_dig_rst_o`=1, `link_up_o`=0.
- R9: `link_up_o` is always the inverse of `rx_dig_rst_o`. Link-ready falls in the same cycle that the reset is applied for any reason.
- R10: In one cycle, priority is PLL loss, then link loss (signal detect in manual mode, frequency lock in automatic mode), then the error flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parallel (word) clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| cdr_auto_i | input | 1 | 1 = automatic CDR lock mode, 0 = manual |
| pll_lock_i | input | 1 | Transmit PLL lock status (asynchronous) |
| freq_lock_i | input | 1 | CDR frequency-lock status (asynchronous) |
| sig_det_i | input | 1 | Receiver signal detect (asynchronous) |
| rx_err_i | input | 1 | FIFO overflow/underflow or data-corruption flag from user logic |
| lock_ref_o | output | 1 | Hold CDR on the reference clock |
| lock_data_o | output | 1 | Let CDR track incoming data |
| rx_dig_rst_o | output | 1 | Receiver digital reset, active high |
| link_up_o | output | 1 | Link ready for traffic |

## Verification
The bench builds the block with a reference dwell of 6 cycles, a data dwell of 4, a stability window of 5 and two synchroniser stages. These short windows let random toggling of PLL lock, frequency lock and signal detect finish whole dwells often. Every state and every priority collision is therefore reached within a few thousand cycles. Each transition can also be counted cycle by cycle against a reference model that follows the requirements. At these values the exact edge counts in R1 to R6 are small numbers, so a miscount of one cycle by the counters or the synchronisers shows up as a mismatch.

// File: rtl/rxrst_pkg.sv
package rxrst_pkg;

   typedef enum logic [2:0] {
      ST_PLL_WAIT   = 3'd0,
      ST_REF_DWELL  = 3'd1,
      ST_DATA_DWELL = 3'd2,
      ST_AUTO_HOLD  = 3'd3,
      ST_LINKED     = 3'd4,
      ST_ERR_PULSE  = 3'd5,
      ST_NO_SIGNAL  = 3'd6
   } rx_state_e;

   typedef struct packed {
      logic lock_ref;
      logic lock_data;
      logic dig_rst;
      logic link_up;
   } rx_ctl_t;

   localparam int unsigned ERR_PULSE_CYC = 2;

   localparam rx_ctl_t CTL_RESET = '{lock_ref: 1'b1, lock_data: 1'b0,
                                     dig_rst: 1'b1, link_up: 1'b0};

   function automatic rx_ctl_t ctl_decode(rx_state_e st, logic auto_mode);
      rx_ctl_t c;
      c = CTL_RESET;
      unique case (st)
         ST_PLL_WAIT,
         ST_REF_DWELL,
         ST_NO_SIGNAL:  c = CTL_RESET;
         ST_DATA_DWELL: c = '{lock_ref: 1'b0, lock_data: 1'b1, dig_rst: 1'b1, link_up: 1'b0};
         ST_AUTO_HOLD:  c = '{lock_ref: 1'b0, lock_data: 1'b0, dig_rst: 1'b1, link_up: 1'b0};
         ST_LINKED:     c = '{lock_ref: 1'b0, lock_data: !auto_mode, dig_rst: 1'b0, link_up: 1'b1};
         ST_ERR_PULSE:  c = '{lock_ref: 1'b0, lock_data: !auto_mode, dig_rst: 1'b1, link_up: 1'b0};
         default:       c = CTL_RESET;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/rxrst_sync.sv
module rxrst_sync #(
   parameter int unsigned WIDTH  = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   if (STAGES < 2) begin : g_bad_stages
      $error("rxrst_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("rxrst_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= '0;
            else        stage_q[g] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= '0;
            else        stage_q[g] <= stage_q[g-1];
         end
      end
   end

   assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/rxrst_dcnt.sv
module rxrst_dcnt #(
   parameter int unsigned LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic done
);

   if (LIMIT < 1) begin : g_bad_limit
      $error("rxrst_dcnt: LIMIT must be at least 1");
   end

   localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
   localparam logic [CW-1:0] RELOAD = CW'(LIMIT - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= RELOAD;
      else if (load)           cnt_q <= RELOAD;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);

endmodule

// File: rtl/rxrst_seq.sv
module rxrst_seq
   import rxrst_pkg::*;
#(
   parameter int unsigned REF_DWELL_CYC   = 2500,
   parameter int unsigned DATA_DWELL_CYC  = 1000,
   parameter int unsigned FREQ_STABLE_CYC = 500,
   parameter int unsigned SYNC_STAGES     = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cdr_auto_i,
   input  logic pll_lock_i,
   input  logic freq_lock_i,
   input  logic sig_det_i,
   input  logic rx_err_i,
   output logic lock_ref_o,
   output logic lock_data_o,
   output logic rx_dig_rst_o,
   output logic link_up_o
);

   localparam int unsigned N_STATUS = 3;

   if (REF_DWELL_CYC < 1 || DATA_DWELL_CYC < 1 || FREQ_STABLE_CYC < 1) begin : g_bad_dwell
      $error("rxrst_seq: every dwell must be at least one cycle");
   end

   // Status synchronisers
   logic [N_STATUS-1:0] status_s;
   logic pll_s, fl_s, sd_s;

   rxrst_sync #(.WIDTH(N_STATUS), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({pll_lock_i, freq_lock_i, sig_det_i}),
      .dout (status_s)
   );

   assign {pll_s, fl_s, sd_s} = status_s;

   // State and mode
   rx_state_e state_q, state_d;
   logic      mode_q, mode_d;
   rx_ctl_t   ctl_q;

   // Dwell counters, each reloading whenever its state is not occupied
   logic ref_done, data_done, stab_done, err_done;

   rxrst_dcnt #(.LIMIT(REF_DWELL_CYC)) u_ref_cnt (
      .clk(clk), .rst_n(rst_n),
      .load(state_q != ST_REF_DWELL), .done(ref_done));

   rxrst_dcnt #(.LIMIT(DATA_DWELL_CYC)) u_data_cnt (
      .clk(clk), .rst_n(rst_n),
      .load(state_q != ST_DATA_DWELL), .done(data_done));

   rxrst_dcnt #(.LIMIT(FREQ_STABLE_CYC)) u_stab_cnt (
      .clk(clk), .rst_n(rst_n),
      .load((state_q != ST_AUTO_HOLD) || !fl_s), .done(stab_done));

   rxrst_dcnt #(.LIMIT(ERR_PULSE_CYC)) u_err_cnt (
      .clk(clk), .rst_n(rst_n),
      .load(state_q != ST_ERR_PULSE), .done(err_done));

   logic link_lost;
   assign link_lost = mode_q ? !fl_s : !sd_s;

   always_comb begin
      state_d = state_q;
      mode_d  = mode_q;
      if (!pll_s) begin
         state_d = ST_PLL_WAIT;
      end else begin
         unique case (state_q)
            ST_PLL_WAIT: begin
               mode_d  = cdr_auto_i;
               state_d = cdr_auto_i ? ST_AUTO_HOLD : ST_REF_DWELL;
            end
            ST_REF_DWELL: begin
               if (!sd_s)         state_d = ST_NO_SIGNAL;
               else if (ref_done) state_d = ST_DATA_DWELL;
            end
            ST_DATA_DWELL: begin
               if (!sd_s)          state_d = ST_NO_SIGNAL;
               else if (data_done) state_d = ST_LINKED;
            end
            ST_AUTO_HOLD: begin
               if (stab_done && fl_s) state_d = ST_LINKED;
            end
            ST_LINKED: begin
               if (link_lost)     state_d = mode_q ? ST_AUTO_HOLD : ST_NO_SIGNAL;
               else if (rx_err_i) state_d = ST_ERR_PULSE;
            end
            ST_ERR_PULSE: begin
               if (err_done) state_d = ST_LINKED;
            end
            ST_NO_SIGNAL: begin
               if (sd_s) state_d = ST_REF_DWELL;
            end
            default: state_d = ST_PLL_WAIT;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_PLL_WAIT;
         mode_q  <= 1'b0;
         ctl_q   <= CTL_RESET;
      end else begin
         state_q <= state_d;
         mode_q  <= mode_d;
         ctl_q   <= ctl_decode(state_d, mode_d);
      end
   end

   assign lock_ref_o   = ctl_q.lock_ref;
   assign lock_data_o  = ctl_q.lock_data;
   assign rx_dig_rst_o = ctl_q.dig_rst;
   assign link_up_o    = ctl_q.link_up;

endmodule

// File: rtl/rxrst_seq_chk.sv
module rxrst_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic mode_q,
   input logic pll_s,
   input logic fl_s,
   input logic sd_s,
   input logic rx_err_i,
   input logic lock_ref_o,
   input logic lock_data_o,
   input logic rx_dig_rst_o,
   input logic link_up_o
);

   // R1
   ref_data_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(lock_ref_o && lock_data_o));

   // R1
   handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_data_o) |-> $fell(lock_ref_o));

   // R2
   rst_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(rx_dig_rst_o) && !mode_q) |-> (lock_data_o && !lock_ref_o));

   // R3
   pll_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pll_s |=> (rx_dig_rst_o && !link_up_o && lock_ref_o && !lock_data_o));

   // R5
   freq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q && link_up_o && !fl_s) |=> (rx_dig_rst_o && !link_up_o));

   // R6
   err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (link_up_o && rx_err_i && pll_s && (mode_q ? fl_s : sd_s))
      |=> rx_dig_rst_o ##1 rx_dig_rst_o);

   // R7
   sd_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_q && link_up_o && !sd_s) |=> (lock_ref_o && !lock_data_o && rx_dig_rst_o));

endmodule

bind rxrst_seq rxrst_seq_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mode_q      (mode_q),
   .pll_s       (pll_s),
   .fl_s        (fl_s),
   .sd_s        (sd_s),
   .rx_err_i    (rx_err_i),
   .lock_ref_o  (lock_ref_o),
   .lock_data_o (lock_data_o),
   .rx_dig_rst_o(rx_dig_rst_o),
   .link_up_o   (link_up_o)
);

// File: tb/sim_rxrst_seq.sv
`timescale 1ns/1ps
module sim_rxrst_seq;

   localparam int REF_C  = 6;
   localparam int DATA_C = 4;
   localparam int STAB_C = 5;
   localparam int SYNC_C = 2;

   localparam int PW = 0, RD = 1, DD = 2, AH = 3, LK = 4, ER = 5, NS = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cdr_auto_i = 1'b0, pll_lock_i = 1'b0, freq_lock_i = 1'b0;
   logic sig_det_i = 1'b0, rx_err_i = 1'b0;
   logic lock_ref_o, lock_data_o, rx_dig_rst_o, link_up_o;

   always #2 clk = ~clk;

   rxrst_seq #(
      .REF_DWELL_CYC(REF_C), .DATA_DWELL_CYC(DATA_C),
      .FREQ_STABLE_CYC(STAB_C), .SYNC_STAGES(SYNC_C)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .cdr_auto_i(cdr_auto_i),
      .pll_lock_i(pll_lock_i), .freq_lock_i(freq_lock_i),
      .sig_det_i(sig_det_i), .rx_err_i(rx_err_i),
      .lock_ref_o(lock_ref_o), .lock_data_o(lock_data_o),
      .rx_dig_rst_o(rx_dig_rst_o), .link_up_o(link_up_o)
   );

   int n_chk = 0, n_fail = 0, cyc = 0;
   bit finished = 1'b0;

   // reference model state
   int m_ph = PW, m_dw = 0, m_run = 0;
   bit m_mode = 1'b0;
   bit mp1, mp2, mf1, mf2, ms1, ms2;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
      end
   endtask

   // expected {lock_ref, lock_data, dig_rst, link_up} per model phase
   function automatic logic [3:0] exp_out(int ph, bit md);
      case (ph)
         DD:      return 4'b0110;
         AH:      return 4'b0010;
         LK:      return {1'b0, !md, 2'b01};
         ER:      return {1'b0, !md, 2'b10};
         default: return 4'b1010;
      endcase
   endfunction

   task automatic model_step();
      int nxt;
      bit lost;
      if (!rst_n) begin
         m_ph = PW; m_dw = 0; m_run = 0; m_mode = 1'b0;
         mp1 = 0; mp2 = 0; mf1 = 0; mf2 = 0; ms1 = 0; ms2 = 0;
         return;
      end
      nxt  = m_ph;
      lost = m_mode ? !mf2 : !ms2;
      if (!mp2) nxt = PW;
      else begin
         case (m_ph)
            PW: begin m_mode = cdr_auto_i; nxt = cdr_auto_i ? AH : RD; end
            RD: if (!ms2) nxt = NS; else if (m_dw + 1 >= REF_C) nxt = DD;
            DD: if (!ms2) nxt = NS; else if (m_dw + 1 >= DATA_C) nxt = LK;
            AH: begin
               m_run = mf2 ? m_run + 1 : 0;
               if (m_run >= STAB_C) nxt = LK;
            end
            LK: if (lost) nxt = m_mode ? AH : NS; else if (rx_err_i) nxt = ER;
            ER: if (m_dw + 1 >= 2) nxt = LK;
            NS: if (ms2) nxt = RD;
            default: nxt = PW;
         endcase
      end
      if (nxt != m_ph) begin m_dw = 0; m_run = 0; end
      else m_dw++;
      m_ph = nxt;
      mp2 = mp1; mp1 = pll_lock_i;
      mf2 = mf1; mf1 = freq_lock_i;
      ms2 = ms1; ms1 = sig_det_i;
   endtask

   task automatic tick();
      logic [3:0] e, a;
      @(posedge clk);
      model_step();
      @(negedge clk);
      e = exp_out(m_ph, m_mode);
      a = {lock_ref_o, lock_data_o, rx_dig_rst_o, link_up_o};
      chk(a[3:2] == e[3:2], "R1 lock controls vs model", a[3:2], e[3:2]);
      chk(a[1] == e[1], "R2 digital reset vs model", a[1], e[1]);
      chk(a[0] == !a[1], "R9 link_up inverse of reset", a[0], !a[1]);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   function automatic bit flip(bit cur, int p_hi, int p_lo);
      int p;
      p = cur ? p_hi : p_lo;
      return (($urandom % p) == 0) ? !cur : cur;
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !finished) begin
         finished = 1'b1;
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
         $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int n;
      void'($urandom(32'd2718));
      // R8 reset state
      ticks(3);
      chk({lock_ref_o, lock_data_o, rx_dig_rst_o, link_up_o} == 4'b1010,
          "R8 reset outputs", {lock_ref_o, lock_data_o, rx_dig_rst_o, link_up_o}, 4'b1010);
      rst_n = 1'b1;
      ticks(2);

      // R1 manual bring-up timing
      cdr_auto_i = 1'b0; sig_det_i = 1'b1; pll_lock_i = 1'b1;
      n = 0;
      do begin tick(); n++; end while (!lock_data_o && n < 100);
      chk(n == REF_C + SYNC_C + 1, "R1 cycles to lock_data", n, REF_C + SYNC_C + 1);
      chk(!lock_ref_o, "R1 lock_ref low at handoff", lock_ref_o, 0);

      // R2 data dwell
      n = 0;
      do begin tick(); n++; end while (rx_dig_rst_o && n < 100);
      chk(n == DATA_C, "R2 data dwell length", n, DATA_C);
      chk(link_up_o, "R2 link up after release", link_up_o, 1);

      // R6 error pulse
      ticks(3);
      rx_err_i = 1'b1; tick(); rx_err_i = 1'b0;
      n = rx_dig_rst_o ? 1 : 0;
      for (int i = 0; i < 4; i++) begin tick(); if (rx_dig_rst_o) n++; end
      chk(n == 2, "R6 error pulse width", n, 2);
      chk(lock_data_o && !lock_ref_o, "R6 lock controls held", {lock_ref_o, lock_data_o}, 1);

      // R7 signal detect loss
      sig_det_i = 1'b0; ticks(SYNC_C + 1);
      chk(lock_ref_o && rx_dig_rst_o && !lock_data_o, "R7 no-signal outputs",
          {lock_ref_o, lock_data_o, rx_dig_rst_o}, 3'b101);
      sig_det_i = 1'b1; ticks(REF_C + DATA_C + 6);
      chk(link_up_o, "R7 relinked after return", link_up_o, 1);

      // R10 link loss beats error in the same cycle
      sig_det_i = 1'b0; ticks(SYNC_C);
      rx_err_i = 1'b1; tick(); rx_err_i = 1'b0;
      chk(lock_ref_o, "R10 loss over error", lock_ref_o, 1);
      sig_det_i = 1'b1; ticks(REF_C + DATA_C + 6);

      // R3 PLL loss
      pll_lock_i = 1'b0; ticks(SYNC_C + 1);
      chk({lock_ref_o, lock_data_o, rx_dig_rst_o, link_up_o} == 4'b1010, "R3 pll loss outputs",
          {lock_ref_o, lock_data_o, rx_dig_rst_o, link_up_o}, 4'b1010);

      // R4 automatic mode
      cdr_auto_i = 1'b1; freq_lock_i = 1'b0; pll_lock_i = 1'b1; ticks(10);
      chk({lock_ref_o, lock_data_o, rx_dig_rst_o} == 3'b001, "R4 auto hold outputs",
          {lock_ref_o, lock_data_o, rx_dig_rst_o}, 3'b001);
      freq_lock_i = 1'b1;
      n = 0;
      do begin tick(); n++; end while (rx_dig_rst_o && n < 100);
      chk(n == STAB_C + SYNC_C, "R4 stability window", n, STAB_C + SYNC_C);

      // R5 frequency lock drop and count restart
      freq_lock_i = 1'b0; ticks(SYNC_C + 1);
      chk(rx_dig_rst_o && !link_up_o, "R5 reset on freq drop", rx_dig_rst_o, 1);
      freq_lock_i = 1'b1; ticks(STAB_C - 1);
      freq_lock_i = 1'b0; tick(); freq_lock_i = 1'b1; ticks(STAB_C + 1);
      chk(rx_dig_rst_o, "R5 count restarted by glitch", rx_dig_rst_o, 1);
      ticks(SYNC_C + 1);
      chk(link_up_o, "R5 relinked after full window", link_up_o, 1);

      // random episodes, checked every cycle against the model
      for (int ep = 0; ep < 40; ep++) begin
         pll_lock_i = 1'b0; ticks(3);
         cdr_auto_i = $urandom % 2;
         pll_lock_i = 1'b1; freq_lock_i = 1'b1; sig_det_i = 1'b1;
         for (int c = 0; c < 200; c++) begin
            pll_lock_i  = flip(pll_lock_i, 300, 4);
            freq_lock_i = flip(freq_lock_i, 40, 5);
            sig_det_i   = flip(sig_det_i, 50, 5);
            rx_err_i    = (($urandom % 30) == 0);
            tick();
         end
         rx_err_i = 1'b0;
      end

      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule